// File: doc/BRIEF.md
# Byte-Addressed Configuration Register Bank

This block holds the configuration, status and error-log registers of a larger chip and makes them reachable over an 8-bit microprocessor port. Every register is 32 bits wide. Software reaches a register either one byte at a time or through a burst of four byte transfers that carry the whole word. A burst starts with the least significant byte.

The 8-bit address splits into three fields. The high field names a clock-domain group, the middle field names a register inside that group, and the two low bits name a byte lane. Each group holds a number of read/write configuration words, one read-only status word mirrored from hardware, and one error-log word. Hardware event pulses set bits in the error log, and the bits stay set until software clears them by writing ones. Power-on reset loads a known preset into every configuration word. All groups run on one clock here.

Top module: `byte_cfg_bank`

## Requirements
- R1: The address is decoded as group = addr[7:5], register index = addr[4:2] and lane = addr[1:0]. Lane 0 maps to bits 7:0, lane 1 to 15:8, lane 2 to 23:16 and lane 3 to 31:24. Groups 0 to 5 are populated. Indices 0 to 3 are read/write configuration words, index 4 is the status word and index 5 is the error log.
- R2: A single-byte write (acc_burst=0) to a configuration word changes only the addressed lane. The new value is visible on cfg_o in the cycle after the access.
- R3: A read access raises rd_valid for exactly one cycle, in the cycle after the access. rd_data then carries the addressed byte as it stood before that clock edge. Cycles without a read access leave rd_valid low.
- R4: A burst is four beats with acc_burst=1. The register is taken from the first beat's address, and that address's lane bits are ignored. Beats carry lanes 0, 1, 2 and 3 in order. A burst write leaves the word untouched until the fourth beat, then commits all 32 bits at once.
- R5: A burst read returns lanes 0 to 3 on the four beats. All four bytes come from the value the word held at the first beat, even if the word changes during the burst.
- R6: A single-byte access that arrives while a burst is under way abandons that burst. The partial bytes are dropped, and the next burst beat counts as a first beat.
- R7: The status word (index 4) reads the sts_i slice of its group. Writes to it have no effect on any register.
- R8: A bit of the error log (index 5) is set in the cycle after its err_evt_i bit is high. It stays set through any number of further events until software clears it.
- R9: Writing 1 to an error-log bit clears it, and writing 0 leaves it alone. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: Addresses in groups 6 and 7, or with indices 6 and 7, read as 0x00. Writes to them change nothing.
- R11: After reset, configuration word r of group g holds 32'hC0DE0000 | (g << 8) | r, every error log holds 0, and rd_valid and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A byte transfer happens this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_burst | input | 1 | 1 = beat of a four-beat burst |
| acc_addr | input | 8 | Group, index and lane |
| acc_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present on rd_data |
| rd_data | output | 8 | Read byte |
| sts_i | input | 192 | Status word per group, group g at bits 32g+31:32g |
| err_evt_i | input | 192 | Error event pulses per group, same packing |
| cfg_o | output | 768 | Configuration words, word r of group g at bits 32(4g+r)+31:32(4g+r) |

## Verification
Two functions can land on the same error bit in the same cycle: a hardware event that sets it and a software write that clears it. The bench provokes this collision with a directed write that clears a bit while the event for that bit is held high. It provokes it again during a long random phase in which sparse events fire while writes of random data hit the error logs. The bench judges the outcome against a behavioural model that applies the clear first and then the event, so the bit must read back as set. A burst read that overlaps a change of its status word is the other overlap the bench drives. There the bytes must come from the first-beat value.

// File: rtl/byte_cfg_bank_pkg.sv
package byte_cfg_bank_pkg;
   localparam int LANE_W = 8;
   localparam int LANES  = 4;
   localparam int REG_W  = LANE_W * LANES;

   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,
      KIND_RW   = 2'd1,
      KIND_STS  = 2'd2,
      KIND_ERR  = 2'd3
   } reg_kind_e;

   // Power-on value of configuration word r in group g
   function automatic logic [REG_W-1:0] preset_word(input int g, input int r);
      return 32'hC0DE_0000 | REG_W'(g << 8) | REG_W'(r);
   endfunction
endpackage

// File: rtl/byte_cfg_bank_decode.sv
module byte_cfg_bank_decode
   import byte_cfg_bank_pkg::*;
#(
   parameter int GRP_W = 3,
   parameter int IDX_W = 3,
   parameter int NGRP  = 6,
   parameter int NRW   = 4
) (
   input  logic [GRP_W+IDX_W-1:0] sel,
   output logic [GRP_W-1:0]       grp,
   output logic [IDX_W-1:0]       idx,
   output reg_kind_e              kind
);
   localparam logic [GRP_W:0]   GRP_LIM = (GRP_W+1)'(NGRP);
   localparam logic [IDX_W:0]   RW_LIM  = (IDX_W+1)'(NRW);
   localparam logic [IDX_W-1:0] STS_IDX = IDX_W'(NRW);
   localparam logic [IDX_W-1:0] ERR_IDX = IDX_W'(NRW + 1);

   assign grp = sel[GRP_W+IDX_W-1 -: GRP_W];
   assign idx = sel[IDX_W-1:0];

   always_comb begin
      kind = KIND_NONE;
      if ({1'b0, grp} < GRP_LIM) begin
         if ({1'b0, idx} < RW_LIM) kind = KIND_RW;
         else if (idx == STS_IDX)  kind = KIND_STS;
         else if (idx == ERR_IDX)  kind = KIND_ERR;
      end
   end
endmodule

// File: rtl/byte_cfg_bank_seq.sv
module byte_cfg_bank_seq
   import byte_cfg_bank_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_wr,
   input  logic              acc_burst,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [LANE_W-1:0] acc_wdata,
   output logic [1:0]        beat,
   output logic [ADDR_W-3:0] reg_sel,
   output logic [1:0]        lane,
   output logic              wr_go,
   output logic [REG_W-1:0]  wr_data,
   output logic [LANES-1:0]  wr_be,
   output logic              rd_go,
   output logic              rd_fresh
);
   localparam int ASM_W = REG_W - LANE_W;

   logic [1:0]        beat_q;
   logic [ADDR_W-3:0] base_q;
   logic [ASM_W-1:0]  asm_q;
   logic              in_burst;

   assign in_burst = acc_valid && acc_burst;
   assign beat     = beat_q;
   assign reg_sel  = (in_burst && beat_q != 2'd0) ? base_q : acc_addr[ADDR_W-1:2];
   assign lane     = acc_burst ? beat_q : acc_addr[1:0];

   assign wr_go    = acc_valid && acc_wr && (!acc_burst || beat_q == 2'd3);
   assign wr_data  = acc_burst ? {acc_wdata, asm_q} : {LANES{acc_wdata}};
   assign wr_be    = acc_burst ? {LANES{1'b1}} : LANES'(1) << lane;
   assign rd_go    = acc_valid && !acc_wr;
   assign rd_fresh = !acc_burst || beat_q == 2'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= 2'd0;
         base_q <= '0;
         asm_q  <= '0;
      end else if (acc_valid) begin
         if (acc_burst) begin
            beat_q <= beat_q + 2'd1;
            if (beat_q == 2'd0) base_q <= acc_addr[ADDR_W-1:2];
            if (acc_wr && beat_q != 2'd3) asm_q[beat_q*LANE_W +: LANE_W] <= acc_wdata;
         end else begin
            beat_q <= 2'd0;
         end
      end
   end
endmodule

// File: rtl/byte_cfg_bank_store.sv
module byte_cfg_bank_store
   import byte_cfg_bank_pkg::*;
#(
   parameter int GRP_W = 3,
   parameter int IDX_W = 3,
   parameter int NGRP  = 6,
   parameter int NRW   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_go,
   input  logic [GRP_W-1:0]          grp,
   input  logic [IDX_W-1:0]          idx,
   input  reg_kind_e                 kind,
   input  logic [REG_W-1:0]          wr_data,
   input  logic [LANES-1:0]          wr_be,
   input  logic [NGRP*REG_W-1:0]     sts_i,
   input  logic [NGRP*REG_W-1:0]     err_evt_i,
   output logic [NGRP*NRW*REG_W-1:0] cfg_o,
   output logic [NGRP*REG_W-1:0]     err_q,
   output logic [REG_W-1:0]          rd_val
);
   logic [REG_W-1:0] mask;

   for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign mask[l*LANE_W +: LANE_W] = {LANE_W{wr_be[l]}};
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic             grp_hit;
      logic [REG_W-1:0] clr;
      logic [REG_W-1:0] err_r;

      assign grp_hit = wr_go && (grp == GRP_W'(g));
      assign clr     = (grp_hit && kind == KIND_ERR) ? (wr_data & mask) : '0;

      for (genvar r = 0; r < NRW; r++) begin : g_word
         logic [REG_W-1:0] word_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_r <= preset_word(g, r);
            else if (grp_hit && kind == KIND_RW && idx == IDX_W'(r))
               word_r <= (word_r & ~mask) | (wr_data & mask);
         end
         assign cfg_o[(g*NRW+r)*REG_W +: REG_W] = word_r;
      end

      // clear first, then the event: a same-cycle event keeps the bit set
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_r <= '0;
         else        err_r <= (err_r & ~clr) | err_evt_i[g*REG_W +: REG_W];
      end
      assign err_q[g*REG_W +: REG_W] = err_r;
   end

   always_comb begin
      rd_val = '0;
      case (kind)
         KIND_RW:  rd_val = cfg_o[(int'(grp)*NRW + int'(idx))*REG_W +: REG_W];
         KIND_STS: rd_val = sts_i[int'(grp)*REG_W +: REG_W];
         KIND_ERR: rd_val = err_q[int'(grp)*REG_W +: REG_W];
         default:  rd_val = '0;
      endcase
   end
endmodule

// File: rtl/byte_cfg_bank.sv
module byte_cfg_bank
   import byte_cfg_bank_pkg::*;
#(
   parameter  int GRP_W  = 3,
   parameter  int IDX_W  = 3,
   parameter  int NGRP   = 6,
   parameter  int NRW    = 4,
   localparam int ADDR_W = GRP_W + IDX_W + 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      acc_valid,
   input  logic                      acc_wr,
   input  logic                      acc_burst,
   input  logic [ADDR_W-1:0]         acc_addr,
   input  logic [LANE_W-1:0]         acc_wdata,
   output logic                      rd_valid,
   output logic [LANE_W-1:0]         rd_data,
   input  logic [NGRP*REG_W-1:0]     sts_i,
   input  logic [NGRP*REG_W-1:0]     err_evt_i,
   output logic [NGRP*NRW*REG_W-1:0] cfg_o
);
   if (NGRP < 1 || NGRP > (1 << GRP_W)) begin : g_bad_ngrp
      $error("NGRP does not fit the group field");
   end
   if (NRW < 1 || NRW + 2 > (1 << IDX_W)) begin : g_bad_nrw
      $error("NRW plus status and error words do not fit the index field");
   end

   logic [1:0]            beat;
   logic [ADDR_W-3:0]     reg_sel;
   logic [1:0]            lane;
   logic                  wr_go, rd_go, rd_fresh;
   logic [REG_W-1:0]      wr_data, rd_val, snap_q;
   logic [LANES-1:0]      wr_be;
   logic [GRP_W-1:0]      grp;
   logic [IDX_W-1:0]      idx;
   reg_kind_e             kind;
   logic [NGRP*REG_W-1:0] err_flat;

   byte_cfg_bank_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
      .acc_burst(acc_burst), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .beat(beat), .reg_sel(reg_sel), .lane(lane), .wr_go(wr_go),
      .wr_data(wr_data), .wr_be(wr_be), .rd_go(rd_go), .rd_fresh(rd_fresh)
   );

   byte_cfg_bank_decode #(.GRP_W(GRP_W), .IDX_W(IDX_W), .NGRP(NGRP), .NRW(NRW)) u_dec (
      .sel(reg_sel), .grp(grp), .idx(idx), .kind(kind)
   );

   byte_cfg_bank_store #(.GRP_W(GRP_W), .IDX_W(IDX_W), .NGRP(NGRP), .NRW(NRW)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .grp(grp), .idx(idx), .kind(kind),
      .wr_data(wr_data), .wr_be(wr_be), .sts_i(sts_i), .err_evt_i(err_evt_i),
      .cfg_o(cfg_o), .err_q(err_flat), .rd_val(rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         snap_q   <= '0;
      end else begin
         rd_valid <= rd_go;
         if (rd_go) begin
            rd_data <= rd_fresh ? rd_val[lane*LANE_W +: LANE_W]
                                : snap_q[lane*LANE_W +: LANE_W];
            if (rd_fresh && acc_burst) snap_q <= rd_val;
         end
      end
   end
endmodule

// File: rtl/byte_cfg_bank_chk.sv
module byte_cfg_bank_chk
   import byte_cfg_bank_pkg::*;
#(
   parameter  int GRP_W  = 3,
   parameter  int IDX_W  = 3,
   parameter  int NGRP   = 6,
   parameter  int NRW    = 4,
   localparam int ADDR_W = GRP_W + IDX_W + 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      acc_valid,
   input logic                      acc_wr,
   input logic                      acc_burst,
   input logic [ADDR_W-1:0]         acc_addr,
   input logic                      rd_valid,
   input logic [LANE_W-1:0]         rd_data,
   input logic [NGRP*NRW*REG_W-1:0] cfg_o,
   input logic [NGRP*REG_W-1:0]     err_evt_i,
   input logic [NGRP*REG_W-1:0]     err_q,
   input logic [1:0]                beat
);
   localparam logic [GRP_W:0]   GRP_LIM = (GRP_W+1)'(NGRP);
   localparam logic [IDX_W-1:0] STS_IDX = IDX_W'(NRW);

   assert_rd_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_wr) |=> rd_valid);
   assert_rd_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && !acc_wr) |=> !rd_valid);
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(cfg_o));
   assert_burst_defer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_burst && beat != 2'd3) |=> $stable(cfg_o));
   assert_abandon_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_burst) |=> beat == 2'd0);
   assert_sts_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_wr && !acc_burst && acc_addr[ADDR_W-3:2] == STS_IDX) |=> $stable(cfg_o));
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_wr) |=> ((err_q & $past(err_q)) == $past(err_q)));
   assert_evt_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((err_q & $past(err_evt_i)) == $past(err_evt_i)));
   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_wr && !acc_burst && {1'b0, acc_addr[ADDR_W-1 -: GRP_W]} >= GRP_LIM)
      |=> rd_data == '0);
endmodule

bind byte_cfg_bank byte_cfg_bank_chk #(
   .GRP_W(GRP_W), .IDX_W(IDX_W), .NGRP(NGRP), .NRW(NRW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
   .acc_burst(acc_burst), .acc_addr(acc_addr), .rd_valid(rd_valid),
   .rd_data(rd_data), .cfg_o(cfg_o), .err_evt_i(err_evt_i),
   .err_q(err_flat), .beat(beat)
);

// File: tb/byte_cfg_bank_tb.sv
module byte_cfg_bank_tb;
   localparam int NGRP = 6;
   localparam int NRW  = 4;
   localparam int W    = 32;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  acc_valid = 1'b0, acc_wr = 1'b0, acc_burst = 1'b0;
   logic [7:0]            acc_addr = '0, acc_wdata = '0;
   logic                  rd_valid;
   logic [7:0]            rd_data;
   logic [NGRP*W-1:0]     sts_i = '0, err_evt_i = '0;
   logic [NGRP*NRW*W-1:0] cfg_o;

   int    total = 0, bad = 0;
   bit    cmp_en = 0, rnd_evt = 0, done = 0;
   string cur_req = "R11";

   always #2.5 clk = ~clk;

   byte_cfg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
      .acc_burst(acc_burst), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .sts_i(sts_i),
      .err_evt_i(err_evt_i), .cfg_o(cfg_o)
   );

   // behavioural reference model
   logic [31:0] m_cfg [NGRP][NRW];
   logic [31:0] m_err [NGRP];
   logic [31:0] m_clr [NGRP];
   logic [31:0] m_snap, m_asm, m_tmp;
   logic [7:0]  m_rd;
   logic        m_rv;
   int          m_beat, m_bg, m_bi;

   function automatic logic [31:0] peek(input int g, input int i);
      if (g >= NGRP) return 32'h0;
      if (i < NRW) return m_cfg[g][i];
      if (i == NRW) return sts_i[g*W +: W];
      if (i == NRW + 1) return m_err[g];
      return 32'h0;
   endfunction

   task automatic apply(input int g, input int i, input logic [31:0] d, input logic [31:0] msk);
      if (g < NGRP) begin
         if (i < NRW) m_cfg[g][i] = (m_cfg[g][i] & ~msk) | (d & msk);
         else if (i == NRW + 1) m_clr[g] = d & msk;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < NGRP; g++) begin
            for (int r = 0; r < NRW; r++) m_cfg[g][r] = 32'hC0DE0000 + g * 256 + r;
            m_err[g] = 0;
         end
         m_rd = 0; m_rv = 0; m_beat = 0; m_snap = 0; m_asm = 0; m_bg = 0; m_bi = 0;
      end else begin
         for (int g = 0; g < NGRP; g++) m_clr[g] = 0;
         m_rv = 0;
         if (acc_valid) begin
            if (acc_burst) begin
               if (m_beat == 0) begin
                  m_bg = int'(acc_addr[7:5]);
                  m_bi = int'(acc_addr[4:2]);
               end
               if (acc_wr) begin
                  if (m_beat < 3) m_asm[m_beat*8 +: 8] = acc_wdata;
                  else apply(m_bg, m_bi, {acc_wdata, m_asm[23:0]}, 32'hFFFF_FFFF);
               end else begin
                  if (m_beat == 0) m_snap = peek(m_bg, m_bi);
                  m_rd = m_snap[m_beat*8 +: 8];
                  m_rv = 1;
               end
               m_beat = (m_beat + 1) % 4;
            end else begin
               m_beat = 0;
               if (acc_wr)
                  apply(int'(acc_addr[7:5]), int'(acc_addr[4:2]), {4{acc_wdata}},
                        32'hFF << (8 * int'(acc_addr[1:0])));
               else begin
                  m_tmp = peek(int'(acc_addr[7:5]), int'(acc_addr[4:2]));
                  m_rd  = m_tmp[8*int'(acc_addr[1:0]) +: 8];
                  m_rv  = 1;
               end
            end
         end
         for (int g = 0; g < NGRP; g++)
            m_err[g] = (m_err[g] & ~m_clr[g]) | err_evt_i[g*W +: W];
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
      total++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
      end
   endtask

   function automatic logic [31:0] cfg_at(input int g, input int r);
      return cfg_o[(g*NRW + r)*W +: W];
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         int k;
         k = 0;
         check({cur_req, " rd_valid"}, {31'b0, rd_valid}, {31'b0, m_rv});
         if (m_rv) check({cur_req, " rd_data"}, {24'b0, rd_data}, {24'b0, m_rd});
         for (int i = NGRP*NRW - 1; i >= 0; i--)
            if (cfg_at(i / NRW, i % NRW) !== m_cfg[i / NRW][i % NRW]) k = i;
         check({cur_req, " cfg_o"}, cfg_at(k / NRW, k % NRW), m_cfg[k / NRW][k % NRW]);
      end
   end

   always @(negedge clk) begin
      if (rnd_evt) begin
         err_evt_i <= ($urandom % 6 == 0) ? ({{(NGRP*W-1){1'b0}}, 1'b1} << ($urandom % (NGRP*W)))
                                          : '0;
         if ($urandom % 16 == 0) sts_i[($urandom % NGRP)*W +: W] <= $urandom;
      end
   end

   task automatic drv(input logic v, input logic wr, input logic bu,
                      input logic [7:0] a, input logic [7:0] d);
      acc_valid = v; acc_wr = wr; acc_burst = bu; acc_addr = a; acc_wdata = d;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drv(0, 0, 0, 8'h00, 8'h00);
   endtask

   task automatic sw(input logic [7:0] a, input logic [7:0] d);
      drv(1, 1, 0, a, d);
   endtask

   task automatic sr(input logic [7:0] a);
      drv(1, 0, 0, a, 8'h00);
   endtask

   task automatic bw(input logic [7:0] a, input logic [31:0] d);
      for (int b = 0; b < 4; b++) drv(1, 1, 1, a, d[b*8 +: 8]);
   endtask

   initial begin
      logic [31:0] keep;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 preset g2r3", cfg_at(2, 3), 32'hC0DE0203);
      check("R11 preset g5r0", cfg_at(5, 0), 32'hC0DE0500);
      check("R11 rd_valid", {31'b0, rd_valid}, 32'h0);
      check("R11 rd_data", {24'b0, rd_data}, 32'h0);
      rst_n = 1'b1;
      cmp_en = 1;
      idle(2);

      cur_req = "R2";
      sw(8'h05, 8'h5A);
      check("R2 lane1 write", cfg_at(0, 1), 32'hC0DE5A01);

      cur_req = "R1 R3";
      sr(8'h05); check("R3 read lane1", {24'b0, rd_data}, 32'h5A);
      sr(8'h07); check("R1 read lane3", {24'b0, rd_data}, 32'hC0);
      sr(8'h04); check("R1 read lane0", {24'b0, rd_data}, 32'h01);
      idle(1);   check("R3 rd_valid drop", {31'b0, rd_valid}, 32'h0);

      cur_req = "R4";
      drv(1, 1, 1, 8'h2A, 8'h44);
      drv(1, 1, 1, 8'h2A, 8'h33);
      check("R4 no partial commit", cfg_at(1, 2), 32'hC0DE0102);
      drv(1, 1, 1, 8'h2A, 8'h22);
      drv(1, 1, 1, 8'h2A, 8'h11);
      check("R4 commit", cfg_at(1, 2), 32'h11223344);
      idle(1);

      cur_req = "R5";
      sts_i[3*W +: W] = 32'hAABBCCDD;
      drv(1, 0, 1, 8'h70, 8'h00); check("R5 beat0", {24'b0, rd_data}, 32'hDD);
      sts_i[3*W +: W] = 32'h0;
      drv(1, 0, 1, 8'h70, 8'h00); check("R5 beat1", {24'b0, rd_data}, 32'hCC);
      drv(1, 0, 1, 8'h70, 8'h00); check("R5 beat2", {24'b0, rd_data}, 32'hBB);
      drv(1, 0, 1, 8'h70, 8'h00); check("R5 beat3", {24'b0, rd_data}, 32'hAA);

      cur_req = "R7";
      sts_i[3*W +: W] = 32'h12345678;
      sw(8'h70, 8'hFF);
      sr(8'h70); check("R7 status lane0", {24'b0, rd_data}, 32'h78);
      sr(8'h73); check("R7 status lane3", {24'b0, rd_data}, 32'h12);

      cur_req = "R8";
      err_evt_i[4*W + 0] = 1'b1; idle(1); err_evt_i[4*W + 0] = 1'b0;
      idle(2);
      err_evt_i[4*W + 5] = 1'b1; err_evt_i[4*W + 0] = 1'b1; idle(1);
      err_evt_i[4*W + 5] = 1'b0; err_evt_i[4*W + 0] = 1'b0;
      sr(8'h94); check("R8 accumulate", {24'b0, rd_data}, 32'h21);

      cur_req = "R9";
      sw(8'h94, 8'h01);
      sr(8'h94); check("R9 w1c", {24'b0, rd_data}, 32'h20);
      err_evt_i[4*W + 5] = 1'b1;
      sw(8'h94, 8'h20);
      err_evt_i[4*W + 5] = 1'b0;
      sr(8'h94); check("R9 set beats clear", {24'b0, rd_data}, 32'h20);

      cur_req = "R10";
      keep = cfg_at(0, 2);
      sr(8'hC0); check("R10 group6 read", {24'b0, rd_data}, 32'h0);
      sr(8'h18); check("R10 index6 read", {24'b0, rd_data}, 32'h0);
      sw(8'h18, 8'hFF);
      sw(8'hE3, 8'hFF);
      check("R10 write ignored", cfg_at(0, 2), keep);

      cur_req = "R6";
      drv(1, 1, 1, 8'h00, 8'h11);
      drv(1, 1, 1, 8'h00, 8'h22);
      sw(8'h03, 8'h77);
      check("R6 abandon", cfg_at(0, 0), 32'h77DE0000);
      bw(8'h00, 32'hCAFEF00D);
      check("R6 restart", cfg_at(0, 0), 32'hCAFEF00D);
      idle(2);

      cur_req = "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random";
      rnd_evt = 1;
      for (int n = 0; n < 2500; n++) begin
         int op;
         logic [7:0] a;
         op = $urandom % 8;
         a  = 8'($urandom);
         if ($urandom % 2 == 0) a[7:5] = 3'($urandom % 6);
         case (op)
            0, 1: idle(1);
            2, 3: sw(a, 8'($urandom));
            4, 5: sr(a);
            default: begin
               for (int b = 0; b < 4; b++) begin
                  if ($urandom % 4 == 0) idle(1);
                  drv(1, op == 6, 1, a, 8'($urandom));
                  if (b == 1 && $urandom % 8 == 0) break;
               end
            end
         endcase
      end
      rnd_evt = 0;
      idle(3);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule